// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block sits in the scanout path of a frame buffer built from three parallel planes: an 8-bit index plane, a 32-bit direct-colour plane and a 32-bit control plane. Each cycle it can take one pixel, carried as one word from each plane, over a valid/ready handshake. A tag byte in the control word decides whether that pixel is shown in true colour or through a 256-entry palette. With tag value 0x03 the pixel is true colour, and the 24-bit RGB value comes straight from the direct-colour word. With any other tag the index byte addresses an external palette memory, which returns its RGB entry one cycle later.

The direct-colour path is delayed by one register stage so that both paths line up with the palette's read latency. The block emits one RGB pixel per cycle with two markers: start-of-line on the first pixel of each row, and end-of-frame on the last pixel of the last row. The visible width and height are run-time inputs, each from 1 to 1024. All planes share a fixed row pitch of 1024 pixels, which is why no visible width may exceed that value. Fetching from memory and generating video timing are done elsewhere.

Top module: `pxmux_direct_index`

## Requirements
- R1: While reset is active and in the first cycle after it, out_valid is 0, in_ready is 1 and pal_rd_en is 0. The first pixel after reset is the start of a frame: it carries start-of-line.
- R2: When the control word's tag byte equals 0x03, the output pixel is direct colour. out_rgb equals in_direct[23:0], with red in bits 23:16, green in 15:8 and blue in 7:0. in_direct[31:24] has no effect on the output.
- R3: For every other tag value (for example 0x00, 0x02, 0x04, 0x83, 0xFF), out_rgb equals the palette entry at address in_index, returned on pal_rd_data, with red in bits 23:16.
- R4: The tag is in_ctrl[31:24], the byte stored first in memory for a big-endian word. in_ctrl[23:0] has no effect, so a word holding 0x03 only in its low byte selects the palette.
- R5: A pixel taken in at one clock edge is presented on the output in the following cycle. With out_ready held high, in_ready stays high and one pixel per cycle passes through.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_rgb, out_sol and out_eof hold their values.
- R7: out_sol is 1 exactly on the first pixel of each row of cfg_width pixels.
- R8: out_eof is 1 exactly on the last pixel of the last row of a cfg_width × cfg_height frame. The next pixel starts a new frame.
- R9: cfg_width and cfg_height take any value from 1 to 1024. A width of 1 marks every pixel as start-of-line, and a width of 1024 is a full row. They may change only between frames.
- R10: pal_rd_en is 1 exactly in the cycles where a pixel is accepted (in_valid and in_ready), with pal_rd_addr equal to in_index. The palette memory keeps pal_rd_data unchanged while pal_rd_en is 0.
- R11: Pixels leave in the order they arrived, none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | 11 | Visible pixels per row, 1 to 1024 |
| cfg_height | input | 11 | Visible rows per frame, 1 to 1024 |
| in_valid | input | 1 | Pixel words on the inputs are valid |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_index | input | 8 | Index-plane byte |
| in_direct | input | 32 | Direct-colour plane word, RGB in bits 23:0 |
| in_ctrl | input | 32 | Control-plane word, tag in bits 31:24 |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_rd_addr | output | 8 | Palette read address |
| pal_rd_data | input | 24 | Palette entry, one cycle after the strobe |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts the output pixel |
| out_rgb | output | 24 | Output colour, red 23:16, green 15:8, blue 7:0 |
| out_sol | output | 1 | First pixel of a row |
| out_eof | output | 1 | Last pixel of a frame |

## Verification
Two things can fall in the same cycle: a stall from the sink and a palette pixel whose colour is still arriving from the external memory. Both must be handled without losing the colour or letting a new read overwrite it. The bench provokes this by driving out_ready from a pseudo-random sequence while it streams pixels with direct and palette tags mixed. Its palette model returns a value that is a function of the address it was given. Every output pixel is compared, in order, against a colour and marker pair computed from the tag rule and from the bench's own row and column counters. A pixel that picked up another pixel's palette entry, or that was repeated or skipped during a stall, shows up as a mismatch.

// File: rtl/pxmux_pkg.sv
package pxmux_pkg;

   // Where the colour of a pixel comes from.
   typedef enum logic {
      SRC_PALETTE = 1'b0,
      SRC_DIRECT  = 1'b1
   } pix_src_e;

   // Raster markers travelling with each pixel.
   typedef struct packed {
      logic sol;
      logic eof;
   } pix_mark_t;

endpackage

// File: rtl/pxmux_tag_decode.sv
module pxmux_tag_decode
   import pxmux_pkg::*;
#(
   parameter int          WORD_W        = 32,
   parameter int          TAG_W         = 8,
   parameter logic [7:0]  DIRECT_TAG    = 8'h03,
   parameter bit          TAG_LANE_SWAP = 1'b0
) (
   input  logic [WORD_W-1:0] ctrl_word,
   output pix_src_e          src
);

   logic [TAG_W-1:0] tag;
   wire unused_ctrl = ^ctrl_word;

   generate
      if (TAG_LANE_SWAP) begin : g_le_lanes
         // bus presents memory byte 0 in the low lane
         assign tag = ctrl_word[TAG_W-1:0];
      end else begin : g_be_lanes
         // memory byte 0 is the most significant byte of the word
         assign tag = ctrl_word[WORD_W-1 -: TAG_W];
      end
   endgenerate

   assign src = (tag == TAG_W'(DIRECT_TAG)) ? SRC_DIRECT : SRC_PALETTE;

endmodule

// File: rtl/pxmux_pos_cnt.sv
module pxmux_pos_cnt
   import pxmux_pkg::*;
#(
   parameter int MAX_WIDTH  = 1024,
   parameter int MAX_HEIGHT = 1024,
   localparam int XW = $clog2(MAX_WIDTH + 1),
   localparam int YW = $clog2(MAX_HEIGHT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [XW-1:0] cfg_width,
   input  logic [YW-1:0] cfg_height,
   output pix_mark_t     mark
);

   logic [XW-1:0] pos_x;
   logic [YW-1:0] pos_y;
   logic          row_last;
   logic          col_last;

   assign row_last = (pos_x == cfg_width  - XW'(1));
   assign col_last = (pos_y == cfg_height - YW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_x <= '0;
         pos_y <= '0;
      end else if (step) begin
         if (row_last) begin
            pos_x <= '0;
            pos_y <= col_last ? '0 : pos_y + YW'(1);
         end else begin
            pos_x <= pos_x + XW'(1);
         end
      end
   end

   assign mark.sol = (pos_x == '0);
   assign mark.eof = row_last && col_last;

   // R9
   pos_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_width != '0) |-> (pos_x < cfg_width));

   // R8
   frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mark.eof) |=> (pos_x == '0 && pos_y == '0));

endmodule

// File: rtl/pxmux_out_stage.sv
module pxmux_out_stage
   import pxmux_pkg::*;
#(
   parameter int RGB_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             out_ready,
   input  pix_src_e         src,
   input  logic [RGB_W-1:0] direct_rgb,
   input  pix_mark_t        mark,
   input  logic [RGB_W-1:0] pal_rgb,
   output logic             stage_free,
   output logic             out_valid,
   output logic [RGB_W-1:0] out_rgb,
   output logic             out_sol,
   output logic             out_eof
);

   logic             s_valid;
   pix_src_e         s_src;
   logic [RGB_W-1:0] s_rgb;
   pix_mark_t        s_mark;

   assign stage_free = !s_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid <= 1'b0;
         s_src   <= SRC_PALETTE;
         s_rgb   <= '0;
         s_mark  <= '0;
      end else if (load) begin
         s_valid <= 1'b1;
         s_src   <= src;
         s_rgb   <= direct_rgb;
         s_mark  <= mark;
      end else if (out_ready) begin
         s_valid <= 1'b0;
      end
   end

   // palette data arrives in the cycle after the read, aligned with s_*
   assign out_valid = s_valid;
   assign out_rgb   = (s_src == SRC_DIRECT) ? s_rgb : pal_rgb;
   assign out_sol   = s_mark.sol;
   assign out_eof   = s_mark.eof;

endmodule

// File: rtl/pxmux_direct_index.sv
module pxmux_direct_index
   import pxmux_pkg::*;
#(
   parameter int         MAX_WIDTH     = 1024,
   parameter int         MAX_HEIGHT    = 1024,
   parameter int         LINE_STRIDE   = 1024,
   parameter int         WORD_W        = 32,
   parameter int         TAG_W         = 8,
   parameter int         IDX_W         = 8,
   parameter int         CH_W          = 8,
   parameter logic [7:0] DIRECT_TAG    = 8'h03,
   parameter bit         TAG_LANE_SWAP = 1'b0
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [$clog2(MAX_WIDTH + 1)-1:0]      cfg_width,
   input  logic [$clog2(MAX_HEIGHT + 1)-1:0]     cfg_height,
   input  logic                                  in_valid,
   output logic                                  in_ready,
   input  logic [IDX_W-1:0]                      in_index,
   input  logic [WORD_W-1:0]                     in_direct,
   input  logic [WORD_W-1:0]                     in_ctrl,
   output logic                                  pal_rd_en,
   output logic [IDX_W-1:0]                      pal_rd_addr,
   input  logic [3*CH_W-1:0]                     pal_rd_data,
   output logic                                  out_valid,
   input  logic                                  out_ready,
   output logic [3*CH_W-1:0]                     out_rgb,
   output logic                                  out_sol,
   output logic                                  out_eof
);

   localparam int RGB_W = 3 * CH_W;

   generate
      if (RGB_W + TAG_W > WORD_W) begin : g_bad_word
         $error("direct colour and tag do not fit in one plane word");
      end
      if (MAX_WIDTH < 1 || MAX_WIDTH > LINE_STRIDE) begin : g_bad_width
         $error("visible width must lie between 1 and the row pitch");
      end
      if (MAX_HEIGHT < 1) begin : g_bad_height
         $error("visible height must be at least 1");
      end
      if (TAG_W != 8) begin : g_bad_tag
         $error("tag is one byte wide");
      end
   endgenerate

   pix_src_e         src;
   pix_mark_t        mark;
   logic             accept;
   logic             stage_free;
   wire              unused_direct = ^in_direct;

   assign in_ready    = stage_free;
   assign accept      = in_valid && stage_free;
   assign pal_rd_en   = accept;
   assign pal_rd_addr = in_index;

   pxmux_tag_decode #(
      .WORD_W        (WORD_W),
      .TAG_W         (TAG_W),
      .DIRECT_TAG    (DIRECT_TAG),
      .TAG_LANE_SWAP (TAG_LANE_SWAP)
   ) u_tag (
      .ctrl_word (in_ctrl),
      .src       (src)
   );

   pxmux_pos_cnt #(
      .MAX_WIDTH  (MAX_WIDTH),
      .MAX_HEIGHT (MAX_HEIGHT)
   ) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (accept),
      .cfg_width  (cfg_width),
      .cfg_height (cfg_height),
      .mark       (mark)
   );

   pxmux_out_stage #(
      .RGB_W (RGB_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .out_ready  (out_ready),
      .src        (src),
      .direct_rgb (in_direct[RGB_W-1:0]),
      .mark       (mark),
      .pal_rgb    (pal_rd_data),
      .stage_free (stage_free),
      .out_valid  (out_valid),
      .out_rgb    (out_rgb),
      .out_sol    (out_sol),
      .out_eof    (out_eof)
   );

   // R6
   hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_rgb) && $stable(out_sol) && $stable(out_eof)));

   // R5
   read_then_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pal_rd_en |=> out_valid);

   // R10
   no_read_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !pal_rd_en);

endmodule

// File: tb/sim_pxmux_direct_index.sv
`timescale 1ns/1ps
module sim_pxmux_direct_index;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [10:0] cfg_width, cfg_height;
   logic        in_valid, in_ready;
   logic [7:0]  in_index;
   logic [31:0] in_direct, in_ctrl;
   logic        pal_rd_en;
   logic [7:0]  pal_rd_addr;
   logic [23:0] pal_rd_data;
   logic        out_valid, out_ready;
   logic [23:0] out_rgb;
   logic        out_sol, out_eof;

   always #4 clk = ~clk;

   pxmux_direct_index u0 (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
      .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
      .in_direct(in_direct), .in_ctrl(in_ctrl), .pal_rd_en(pal_rd_en),
      .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
      .out_sol(out_sol), .out_eof(out_eof)
   );

   typedef struct {
      logic [23:0] rgb;
      logic        sol;
      logic        eof;
      int unsigned cyc;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          fails  = 0;
   int unsigned cyc    = 0;
   bit          lat_on = 1'b0;
   bit          rnd_ready = 1'b0;
   bit          force_ready = 1'b1;
   bit          done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   int          bx, by, bw, bh;

   function automatic logic [23:0] pal_val(input logic [7:0] a);
      return {a, ~a, a ^ 8'h5A};
   endfunction

   // palette memory model: registered read, holds when not strobed
   logic [23:0] pal_q = 24'h0;
   always @(posedge clk) if (pal_rd_en) pal_q <= pal_val(pal_rd_addr);
   assign pal_rd_data = pal_q;

   always @(posedge clk) cyc <= cyc + 1;

   // sink readiness, changed only at falling edges
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rnd_ready ? lfsr[0] : force_ready;
   end

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      #2;
      if (rst_n === 1'b1 && out_valid === 1'b1 && out_ready === 1'b1) begin
         if (sb.size() == 0) begin
            check(1'b0, "R11 output with nothing expected", 32'(out_rgb), 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_rgb === e.rgb, "R2/R3 pixel colour", 32'(out_rgb), 32'(e.rgb));
            check(out_sol === e.sol, "R7 start-of-line", 32'(out_sol), 32'(e.sol));
            check(out_eof === e.eof, "R8 end-of-frame", 32'(out_eof), 32'(e.eof));
            if (lat_on)
               check(cyc == e.cyc + 1, "R5 one-cycle latency", cyc, e.cyc + 1);
         end
      end
   end

   task automatic set_size(input int w, input int h);
      cfg_width  = 11'(w);
      cfg_height = 11'(h);
      bw = w; bh = h; bx = 0; by = 0;
   endtask

   task automatic send(input logic [31:0] ctrl, input logic [31:0] dir,
                       input logic [7:0] idx);
      exp_t e;
      @(negedge clk);
      in_valid  = 1'b1;
      in_ctrl   = ctrl;
      in_direct = dir;
      in_index  = idx;
      #1;
      while (in_ready !== 1'b1) begin
         if (out_ready === 1'b1)
            check(1'b0, "R5 ready dropped while sink ready", 32'(in_ready), 32'h1);
         @(negedge clk);
         #1;
      end
      check(pal_rd_en === 1'b1 && pal_rd_addr === idx, "R10 palette read strobe",
            {23'h0, pal_rd_en, pal_rd_addr}, {23'h0, 1'b1, idx});
      e.rgb = (ctrl[31:24] == 8'h03) ? dir[23:0] : pal_val(idx);
      e.sol = (bx == 0);
      e.eof = (bx == bw - 1) && (by == bh - 1);
      if (bx == bw - 1) begin
         bx = 0;
         by = (by == bh - 1) ? 0 : by + 1;
      end else begin
         bx = bx + 1;
      end
      @(posedge clk);
      e.cyc = cyc;
      sb.push_back(e);
   endtask

   task automatic drain();
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check(pal_rd_en === 1'b0, "R10 no read without a pixel", 32'(pal_rd_en), 32'h0);
      while (sb.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [7:0] pal_tag(input int i);
      case (i % 6)
         0: return 8'h00;
         1: return 8'h02;
         2: return 8'h04;
         3: return 8'h83;
         4: return 8'hFF;
         default: return 8'h30;
      endcase
   endfunction

   task automatic send_mixed(input int i);
      if (i % 3 == 0)
         send({8'h03, 24'(i * 7919)}, {8'(i) ^ 8'hC3, 24'(i * 40503 + 5)}, 8'(i * 11));
      else if (i % 3 == 1)
         send(32'h0000_0003, {8'h03, 24'(i * 977)}, 8'(i * 29 + 1));
      else
         send({pal_tag(i), 24'h03_0303}, 32'hFFFF_FFFF, 8'(255 - i));
   endtask

   initial begin
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_ctrl   = '0;
      in_direct = '0;
      in_index  = '0;
      set_size(4, 3);
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // R1 reset state
      check(out_valid === 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'h0);
      check(in_ready === 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'h1);
      check(pal_rd_en === 1'b0, "R1 pal_rd_en in reset", 32'(pal_rd_en), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(out_valid === 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);

      // R3 R7 R8: palette-only frame 4x3, full throughput (R5)
      lat_on = 1'b1;
      for (int i = 0; i < 12; i++)
         send({pal_tag(i), 24'hABCDEF ^ 24'(i)}, 32'h1234_5678 + 32'(i), 8'(i * 37));
      drain();

      // R2 R4: mixed tags, junk upper direct byte and low control bits
      set_size(5, 2);
      for (int i = 0; i < 20; i++) send_mixed(i);
      drain();

      // R6 R11: random backpressure over three 3x4 frames
      lat_on = 1'b0;
      rnd_ready = 1'b1;
      set_size(3, 4);
      for (int i = 0; i < 36; i++) send_mixed(i + 100);
      drain();
      rnd_ready = 1'b0;
      repeat (2) @(negedge clk);

      // R9 narrow: width 1, every pixel starts a row
      lat_on = 1'b1;
      set_size(1, 2);
      for (int i = 0; i < 6; i++) send_mixed(i + 7);
      drain();

      // R9 wide: full 1024-pixel rows, two frames of 1024x1 with stalls
      rnd_ready = 1'b1;
      lat_on = 1'b0;
      set_size(1024, 1);
      for (int i = 0; i < 2048; i++) send_mixed(i);
      drain();
      rnd_ready = 1'b0;

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule